// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

This block is a synchronous two-port word memory. Each port has its own address, write data, active-low select, output enable, write enable, upper and lower byte selects and an active-low busy input. Both ports may read or write any word in the same clock cycle. Writes take effect at the clock edge. Read data is registered and appears on the cycle after the request.

The two highest addresses also serve as doorbells between the ports. A write by one port to the other port's mailbox word raises that other port's active-low interrupt. The interrupt drops again when its owner touches its own mailbox word with select and output enable low. The mailbox words keep whatever data is written to them, like any other word.

`ADDR_W` sets the depth. The default of 10 gives 1024 words; 14 gives the full 16K x 16 array, with mailboxes at 0x3FFE and 0x3FFF. Port A's mailbox is address `DEPTH-2` (0x3FE by default). Port B's mailbox is address `DEPTH-1` (0x3FF by default).

Top module: `mbxRam`

## Requirements
- R1: A write happens when select is low, write enable is low, busy is high and at least one byte select is low. It updates only the selected lanes: upper select controls bits 15:8, lower select controls bits 7:0.
- R2: A read request is select low, write enable high, output enable low and at least one byte select low. On the next cycle, read data carries the stored word in the selected lanes and zero in the deselected lanes. In every other case, read data is zero on the next cycle.
- R3: With select high, or with both byte selects high, a port changes no memory word and no interrupt flag.
- R4: A write by port B to address DEPTH-2 drives port A's interrupt low from the next cycle. It stays low until cleared.
- R5: Port A clears its interrupt when it has select and output enable low at address DEPTH-2, whatever its write enable.
- R6: A write by port A to address DEPTH-1 drives port B's interrupt low. Port B clears it by a select-and-output-enable access to DEPTH-1.
- R7: While a port's busy input is low, its writes are dropped and it can neither set nor clear any interrupt. Its reads still return data.
- R8: When a set and a clear of the same interrupt fall in the same cycle, the interrupt ends that cycle asserted.
- R9: After reset, both interrupts are high and both read data outputs are zero.
- R10: The mailbox words are stored like any other word, and both ports can read and write them.
- R11: When one port reads a word that the other port writes in the same cycle, the read returns the word as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| aAddr | input | ADDR_W | Port A word address |
| aWrData | input | DATA_W | Port A write data |
| aCsN | input | 1 | Port A select, active low |
| aOeN | input | 1 | Port A output enable, active low |
| aWeN | input | 1 | Port A write enable, active low |
| aUbN | input | 1 | Port A upper byte select, active low |
| aLbN | input | 1 | Port A lower byte select, active low |
| aBusyN | input | 1 | Port A busy, active low; low blocks writes and flag actions |
| aRdData | output | DATA_W | Port A registered read data |
| aIntN | output | 1 | Port A interrupt, active low |
| bAddr | input | ADDR_W | Port B word address |
| bWrData | input | DATA_W | Port B write data |
| bCsN | input | 1 | Port B select, active low |
| bOeN | input | 1 | Port B output enable, active low |
| bWeN | input | 1 | Port B write enable, active low |
| bUbN | input | 1 | Port B upper byte select, active low |
| bLbN | input | 1 | Port B lower byte select, active low |
| bBusyN | input | 1 | Port B busy, active low; low blocks writes and flag actions |
| bRdData | output | DATA_W | Port B registered read data |
| bIntN | output | 1 | Port B interrupt, active low |

## Verification
Two pairs of events can land in the same cycle. The first pair is a doorbell set from one port and a clear from the owner of that mailbox. The second pair is a write from one port and a read of the same word from the other. Directed steps place each pair in one cycle on purpose. A long random phase then draws addresses heavily from the two mailbox words and one shared word, so both pairs recur under mixed busy and byte-select patterns. A behavioural model in the bench evaluates reads before writes and applies a set after a clear. Every cycle it predicts both read buses and both interrupts, and the bench compares them against the outputs.

// File: rtl/mbxPkg.sv
`timescale 1ns/1ps
package mbxPkg;
  localparam int LANES = 2;

  // per-port strobes from control to datapath
  typedef struct packed {
    logic             wr;
    logic             rd;
    logic [LANES-1:0] lane;
  } portStb_t;
endpackage

// File: rtl/mbxCtrl.sv
`timescale 1ns/1ps
module mbxCtrl
  import mbxPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        csN,
  input  logic [1:0]        oeN,
  input  logic [1:0]        weN,
  input  logic [1:0]        ubN,
  input  logic [1:0]        lbN,
  input  logic [1:0]        busyN,
  input  logic [ADDR_W-1:0] addr [2],
  output portStb_t          stb  [2],
  output logic [1:0]        intN
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam int Q = 1 - p;
    localparam logic [ADDR_W-1:0] MBOX = ADDR_W'(DEPTH - 2 + p);

    logic [LANES-1:0] laneSel;
    logic anyLane, wrOk, rdOk, touch, setReq, clrReq, flagQ;

    assign laneSel = ~{ubN[p], lbN[p]};
    assign anyLane = |laneSel;
    assign wrOk    = !csN[p] && !weN[p] && busyN[p] && anyLane;
    assign rdOk    = !csN[p] && weN[p] && !oeN[p] && anyLane;
    assign touch   = !csN[p] && !oeN[p] && busyN[p] && anyLane;
    assign stb[p]  = '{wr: wrOk, rd: rdOk, lane: laneSel};

    // doorbell: other port writes my mailbox; I clear by touching it
    assign setReq = stb[Q].wr && (addr[Q] == MBOX);
    assign clrReq = touch && (addr[p] == MBOX);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       flagQ <= 1'b0;
      else if (setReq) flagQ <= 1'b1;
      else if (clrReq) flagQ <= 1'b0;
    end
    assign intN[p] = ~flagQ;

    // R4 R6
    doorbellSet_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!csN[Q] && !weN[Q] && busyN[Q] && (!ubN[Q] || !lbN[Q]) && addr[Q] == MBOX)
      |=> !intN[p]);

    // R5
    doorbellClr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!csN[p] && !oeN[p] && busyN[p] && (!ubN[p] || !lbN[p]) && addr[p] == MBOX
       && !(stb[Q].wr && addr[Q] == MBOX))
      |=> intN[p]);

    // R7
    busyFreeze_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!busyN[p] && !busyN[Q]) |=> $stable(intN[p]));
  end
endmodule

// File: rtl/mbxData.sv
`timescale 1ns/1ps
module mbxData
  import mbxPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  portStb_t               stb    [2],
  input  logic [ADDR_W-1:0]      addr   [2],
  input  logic [1:0][DATA_W-1:0] wrData,
  output logic [1:0][DATA_W-1:0] rdData
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] mem [DEPTH];

  // port B is applied after port A; same-word double writes are outside the contract
  always_ff @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      for (int l = 0; l < LANES; l++) begin
        if (stb[p].wr && stb[p].lane[l])
          mem[addr[p]][l*LANE_W +: LANE_W] <= wrData[p][l*LANE_W +: LANE_W];
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [DATA_W-1:0] rdReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdReg <= '0;
      end else begin
        for (int l = 0; l < LANES; l++)
          rdReg[l*LANE_W +: LANE_W] <= (stb[p].rd && stb[p].lane[l])
                                       ? mem[addr[p]][l*LANE_W +: LANE_W] : '0;
      end
    end
    assign rdData[p] = rdReg;

    // R2
    idleRead_chk: assert property (@(posedge clk) disable iff (!rstN)
      !stb[p].rd |=> (rdReg == '0));
  end
endmodule

// File: rtl/mbxRam.sv
`timescale 1ns/1ps
module mbxRam
  import mbxPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWrData,
  input  logic              aCsN,
  input  logic              aOeN,
  input  logic              aWeN,
  input  logic              aUbN,
  input  logic              aLbN,
  input  logic              aBusyN,
  output logic [DATA_W-1:0] aRdData,
  output logic              aIntN,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWrData,
  input  logic              bCsN,
  input  logic              bOeN,
  input  logic              bWeN,
  input  logic              bUbN,
  input  logic              bLbN,
  input  logic              bBusyN,
  output logic [DATA_W-1:0] bRdData,
  output logic              bIntN
);
  logic [ADDR_W-1:0]      addrArr [2];
  logic [1:0][DATA_W-1:0] wrArr, rdArr;
  logic [1:0]             intArr;
  portStb_t               stb [2];

  assign addrArr[0] = aAddr;
  assign addrArr[1] = bAddr;
  assign wrArr      = {bWrData, aWrData};

  mbxCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .csN   ({bCsN, aCsN}),
    .oeN   ({bOeN, aOeN}),
    .weN   ({bWeN, aWeN}),
    .ubN   ({bUbN, aUbN}),
    .lbN   ({bLbN, aLbN}),
    .busyN ({bBusyN, aBusyN}),
    .addr  (addrArr),
    .stb   (stb),
    .intN  (intArr)
  );

  mbxData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .addr   (addrArr),
    .wrData (wrArr),
    .rdData (rdArr)
  );

  assign aRdData = rdArr[0];
  assign bRdData = rdArr[1];
  assign aIntN   = intArr[0];
  assign bIntN   = intArr[1];
endmodule

// File: tb/mbxRam_bench.sv
`timescale 1ns/1ps
module mbxRam_bench;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] MBA = AW'(DEPTH - 2);
  localparam logic [AW-1:0] MBB = AW'(DEPTH - 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] addr [2];
  logic [DW-1:0] wd   [2];
  logic cs [2], oe [2], we [2], ub [2], lb [2], busy [2];
  wire  [DW-1:0] rdA, rdB;
  wire  intA, intB;

  mbxRam #(.ADDR_W(AW), .DATA_W(DW)) u_mbxRam (
    .clk(clk), .rstN(rstN),
    .aAddr(addr[0]), .aWrData(wd[0]), .aCsN(cs[0]), .aOeN(oe[0]), .aWeN(we[0]),
    .aUbN(ub[0]), .aLbN(lb[0]), .aBusyN(busy[0]), .aRdData(rdA), .aIntN(intA),
    .bAddr(addr[1]), .bWrData(wd[1]), .bCsN(cs[1]), .bOeN(oe[1]), .bWeN(we[1]),
    .bUbN(ub[1]), .bLbN(lb[1]), .bBusyN(busy[1]), .bRdData(rdB), .bIntN(intB)
  );

  logic [DW-1:0] refMem [DEPTH];
  logic [DW-1:0] expRd [2];
  logic expFlag [2];
  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic check1(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic idleAll();
    for (int p = 0; p < 2; p++) begin
      addr[p] = '0; wd[p] = '0; cs[p] = 1; oe[p] = 1; we[p] = 1;
      ub[p] = 1; lb[p] = 1; busy[p] = 1;
    end
  endtask

  // p, address, data, select, oe, we, upper, lower, busy (all active low)
  task automatic acc(int p, logic [AW-1:0] a, logic [DW-1:0] d, logic c, logic o,
                     logic w, logic u, logic l, logic b);
    addr[p] = a; wd[p] = d; cs[p] = c; oe[p] = o; we[p] = w;
    ub[p] = u; lb[p] = l; busy[p] = b;
  endtask

  // reference model: reads see the old word, then writes, then flags (set after clear)
  task automatic modelStep();
    logic [DW-1:0] old [2];
    logic [1:0] ln [2];
    logic wr [2], rd [2], touch [2];
    for (int p = 0; p < 2; p++) begin
      old[p] = refMem[addr[p]];
      ln[p] = {!ub[p], !lb[p]};
      wr[p] = !cs[p] && !we[p] && busy[p] && (ln[p] != 2'b00);
      rd[p] = !cs[p] && we[p] && !oe[p] && (ln[p] != 2'b00);
      touch[p] = !cs[p] && !oe[p] && busy[p] && (ln[p] != 2'b00);
      expRd[p] = rd[p] ? {ln[p][1] ? old[p][15:8] : 8'h00, ln[p][0] ? old[p][7:0] : 8'h00}
                       : 16'h0000;
    end
    for (int p = 0; p < 2; p++) begin
      if (wr[p]) begin
        if (ln[p][1]) refMem[addr[p]][15:8] = wd[p][15:8];
        if (ln[p][0]) refMem[addr[p]][7:0]  = wd[p][7:0];
      end
    end
    for (int p = 0; p < 2; p++) begin
      logic [AW-1:0] mb;
      mb = (p == 0) ? MBA : MBB;
      if (touch[p] && addr[p] == mb) expFlag[p] = 1'b0;
      if (wr[1-p] && addr[1-p] == mb) expFlag[p] = 1'b1;
    end
  endtask

  task automatic step(string tag);
    modelStep();
    @(negedge clk);
    check1(tag, "rdA", rdA, expRd[0]);
    check1(tag, "rdB", rdB, expRd[1]);
    check1(tag, "intA", {15'h0, intA}, {15'h0, !expFlag[0]});
    check1(tag, "intB", {15'h0, intB}, {15'h0, !expFlag[1]});
    idleAll();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idleAll();
    expFlag[0] = 0; expFlag[1] = 0; expRd[0] = '0; expRd[1] = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check1("R9", "rdA", rdA, 16'h0);
    check1("R9", "rdB", rdB, 16'h0);
    check1("R9", "intA", {15'h0, intA}, 16'h1);
    check1("R9", "intB", {15'h0, intB}, 16'h1);
    rstN = 1'b1;

    for (int i = 0; i < DEPTH; i++) begin
      acc(0, AW'(i), DW'(i * 3) ^ 16'h5a5a, 0, 1, 0, 0, 0, 1);
      step("R1 fill");
    end
    acc(1, MBB, 0, 0, 0, 1, 0, 0, 1); step("R6 clear after fill");

    acc(0, 5, 16'h1234, 0, 1, 0, 0, 0, 1); step("R1 full write");
    acc(0, 5, 0, 0, 0, 1, 0, 0, 1);        step("R2 read both");
    acc(1, 5, 16'hAB99, 0, 1, 0, 0, 1, 1); step("R1 upper only");
    acc(0, 5, 0, 0, 0, 1, 1, 0, 1);        step("R2 read lower");
    acc(0, 5, 0, 0, 0, 1, 0, 1, 1);        step("R2 read upper");
    acc(0, 5, 0, 0, 0, 1, 0, 0, 1);        step("R1 merged word");

    acc(0, 5, 16'hFFFF, 0, 1, 0, 1, 1, 1); step("R3 no lanes");
    acc(1, 5, 16'hEEEE, 1, 1, 0, 0, 0, 1); step("R3 deselected");
    acc(1, MBA, 16'hEEEE, 0, 1, 0, 1, 1, 1); step("R3 mailbox no lanes");
    acc(0, 5, 0, 0, 0, 1, 0, 0, 1);        step("R3 readback");

    acc(1, MBA, 16'hC0DE, 0, 1, 0, 0, 0, 1); step("R4 set");
    step("R4 hold");
    acc(1, MBA, 0, 0, 0, 1, 0, 0, 1);      step("R10 other reads mailbox");
    acc(0, MBA, 16'h4242, 0, 0, 0, 0, 0, 1); step("R5 clear by write");
    acc(0, MBA, 0, 0, 0, 1, 0, 0, 1);      step("R10 owner reads mailbox");

    acc(0, MBB, 16'h00F1, 0, 1, 0, 1, 0, 1); step("R6 set");
    acc(1, MBB, 0, 0, 0, 1, 0, 0, 1);      step("R6 clear by read");

    acc(1, MBA, 16'hDEAD, 0, 1, 0, 0, 0, 0); step("R7 busy write");
    acc(0, MBA, 0, 0, 0, 1, 0, 0, 1);      step("R7 data kept");
    acc(1, MBA, 16'hBEEF, 0, 1, 0, 0, 0, 1); step("R7 set");
    acc(0, MBA, 0, 0, 0, 1, 0, 0, 0);      step("R7 busy blocks clear");
    acc(0, MBA, 0, 0, 0, 1, 0, 0, 1);      step("R7 clear");

    acc(1, MBA, 16'h1111, 0, 1, 0, 0, 0, 1);
    acc(0, MBA, 0, 0, 0, 1, 0, 0, 1);      step("R8 set beats clear");
    acc(0, MBA, 0, 0, 0, 1, 0, 0, 1);      step("R8 later clear");

    acc(0, 9, 16'h7777, 0, 1, 0, 0, 0, 1);
    acc(1, 9, 0, 0, 0, 1, 0, 0, 1);        step("R11 old word");
    acc(1, 9, 0, 0, 0, 1, 0, 0, 1);        step("R11 new word");

    for (int n = 0; n < 4000; n++) begin
      for (int p = 0; p < 2; p++) begin
        int r;
        r = int'($urandom % 8);
        addr[p] = (r < 2) ? MBA : (r < 4) ? MBB : (r < 6) ? AW'(3) : AW'($urandom);
        wd[p]   = DW'($urandom);
        cs[p]   = 1'($urandom % 5 == 0);
        oe[p]   = 1'($urandom % 2);
        we[p]   = 1'($urandom % 2);
        ub[p]   = 1'($urandom % 4 == 0);
        lb[p]   = 1'($urandom % 4 == 0);
        busy[p] = 1'($urandom % 6 != 0);
      end
      if (!cs[0] && !we[0] && !cs[1] && !we[1] && addr[0] == addr[1]) we[1] = 1'b1;
      step("random R1 R2 R4 R5 R6 R7 R8 R11");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule